// File: doc/BRIEF.md
# Context-Tagged Virtual Write-Through Cache

This block is a direct-mapped data cache looked up entirely by virtual address. Each line's tag holds, besides the address tag, the number of the address space (context) that filled it and two permission bits captured from the page table entry at fill time. A lookup therefore needs no translation: a hit demands a valid line, a matching address tag and a matching context. The cached permission bits let the cache refuse a store to a read-only line, or a user access to a supervisor-only line, on its own.

The processor side issues one load or store at a time with a virtual address, its context, a supervisor flag, write data with byte enables, and the two permission bits that go into the tag if the access fills a line. Stores always go out to memory, hit or miss. A load miss fetches the whole 16-byte line as four word reads. A separate maintenance port reads and writes raw tag words, which also serves to flush lines. A level input turns caching on or off; while it is off every access goes straight to memory. After reset the block sweeps the tag array to invalidate every line before it accepts work.

Top module: `ctag_cache`

## Requirements
- R1: After reset, req_ready and mt_ready stay low for at least NUM_LINES cycles while every tag word is cleared; a maintenance read of any line afterwards returns 0.
- R2: The address splits as tag bits 29:16, line index bits starting at bit 4 (bits 15:4 at 4096 lines; with fewer lines the unused index bits above the index are compared as an extra tag), word bits 3:2 and byte bits 1:0; bits 31:30 take no part in the lookup, so an address differing from a cached one only there hits.
- R3: A load miss with caching on issues four memory reads at the line base plus 0, 4, 8 and 12, in that order, then marks the line valid with the request's context and permission bits; the response returns the word the load addressed.
- R4: A hit needs the valid bit set, the stored tag equal to address bits 29:16 and the stored context equal to req_ctx; a load hit returns the cached word with no memory access, and a mismatch of context or tag causes a refill.
- R5: Every store that is not faulted produces exactly one memory write with the word address, write data and byte enables of the request, whether it hits or misses; a store miss does not allocate, so a later load to it misses.
- R6: A store hit updates exactly the cached bytes whose req_be bit is set (bit n covers data bits 8n+7:8n).
- R7: With caching on, a store hitting a line whose write bit is 0, or a user access (req_super 0) hitting a line whose privileged bit is 1, returns rsp_fault 1 with rsp_rdata 0, performs no memory access and leaves the cache unchanged.
- R8: A maintenance read returns, one cycle after acceptance on mt_rtag, the tag word with context in bits 24:22, write permission in bit 21, privileged in bit 20, valid in bit 19 and tag in bits 15:2; all other bits read 0.
- R9: A maintenance write replaces the whole tag of the line selected by mt_addr, with the zero fields forced to 0; writing valid 0 flushes the line so the next load to it misses.
- R10: While cache_en is 0 at acceptance, a load is one memory read and a store one memory write, no fault is raised and the cache is neither filled nor updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cache_en | input | 1 | 1 = caching on, 0 = every access bypasses the cache |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual address |
| req_ctx | input | 3 | Current context |
| req_super | input | 1 | 1 = supervisor access |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| req_pte_w | input | 1 | Write permission to record on a fill |
| req_pte_p | input | 1 | Privileged flag to record on a fill |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Load data (0 for stores and faults) |
| rsp_fault | output | 1 | Protection fault on this response |
| mem_req | output | 1 | Memory word access pending |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | Memory access done; read data valid |
| mem_rdata | input | 32 | Memory read data |
| mt_valid | input | 1 | Maintenance access present |
| mt_ready | output | 1 | Maintenance access accepted when high with mt_valid |
| mt_write | input | 1 | 1 = tag write, 0 = tag read |
| mt_addr | input | 32 | Address selecting the line |
| mt_wtag | input | 32 | Tag word to write |
| mt_rtag | output | 32 | Tag word read |

## Verification
A corrupted tag or valid bit shows up on the very next access to that line as a wrong count of memory reads (zero instead of four, or four instead of zero) or as a spurious or missing fault, and a maintenance read exposes the raw word one cycle after it is accepted. Corrupted line data appears as a wrong word on the next load hit, and a bad byte-enable merge shows in the read-back after one store. Broken write-through is visible at once as a missing or extra memory write for each store. Sweeping every line, every byte-enable pattern and each fault condition makes these visible within a few requests of the fault.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam int TID_W = 14;
  localparam int CTX_W = 3;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic             wr_ok;
    logic             priv;
    logic             vld;
    logic [TID_W-1:0] tid;
  } ctc_tag_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WRITE,
    ST_FILL,
    ST_BYP
  } ctc_state_t;

  function automatic logic [31:0] ctc_pack(input ctc_tag_t t);
    return {7'd0, t.ctx, t.wr_ok, t.priv, t.vld, 3'd0, t.tid, 2'd0};
  endfunction

  function automatic ctc_tag_t ctc_unpack(input logic [31:0] w);
    ctc_tag_t t;
    t.ctx   = w[24:22];
    t.wr_ok = w[21];
    t.priv  = w[20];
    t.vld   = w[19];
    t.tid   = w[15:2];
    return t;
  endfunction

endpackage

// File: rtl/ctc_tag_store.sv
module ctc_tag_store
  import ctc_pkg::*;
#(
  parameter int LINES   = 4096,
  parameter int IDX_W   = 12,
  parameter bit USE_EXT = 1'b0,
  parameter int EXT_WP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              busy,
  input  logic [IDX_W-1:0]  rd_idx,
  output ctc_tag_t          rd_tag,
  output logic [EXT_WP-1:0] rd_ext,
  input  logic [IDX_W-1:0]  mrd_idx,
  output ctc_tag_t          mrd_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  ctc_tag_t          wr_tag,
  input  logic [EXT_WP-1:0] wr_ext
);

  ctc_tag_t tag_mem [LINES];

  logic [IDX_W-1:0] cnt_q, cnt_n;
  logic             busy_n;
  logic             we;
  logic [IDX_W-1:0] widx;
  ctc_tag_t         wdat;

  always_comb begin
    busy_n = busy;
    cnt_n  = cnt_q;
    if (busy) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == IDX_W'(LINES - 1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else begin
      busy  <= busy_n;
      cnt_q <= cnt_n;
    end
  end

  always_comb begin
    we   = busy | wr_en;
    widx = busy ? cnt_q : wr_idx;
    wdat = busy ? '0 : wr_tag;
  end

  always_ff @(posedge clk) begin
    if (we) tag_mem[widx] <= wdat;
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign mrd_tag = tag_mem[mrd_idx];

  generate
    if (USE_EXT) begin : g_ext
      logic [EXT_WP-1:0] ext_mem [LINES];
      always_ff @(posedge clk) begin
        if (we) ext_mem[widx] <= busy ? '0 : wr_ext;
      end
      assign rd_ext = ext_mem[rd_idx];
    end else begin : g_noext
      logic unused_ext;
      assign unused_ext = ^wr_ext;
      assign rd_ext     = '0;
    end
  endgenerate

  // R1
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(rst_n) |-> cnt_q == $past(cnt_q) + 1'b1);

  // R1
  sweep_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt_q) == IDX_W'(LINES - 1));

endmodule

// File: rtl/ctc_data_store.sv
module ctc_data_store #(
  parameter int LINES = 4096,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_word,
  output logic [31:0]      rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_word,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data
);

  logic [127:0] line_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wr_be[b]) line_mem[wr_idx][{wr_word, b[1:0], 3'b000} +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  assign rd_data = line_mem[rd_idx][{rd_word, 5'd0} +: 32];

endmodule

// File: rtl/ctag_cache.sv
module ctag_cache
  import ctc_pkg::*;
#(
  parameter int NUM_LINES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_en,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_vaddr,
  input  logic [2:0]  req_ctx,
  input  logic        req_super,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_be,
  input  logic        req_pte_w,
  input  logic        req_pte_p,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_fault,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mt_valid,
  output logic        mt_ready,
  input  logic        mt_write,
  input  logic [31:0] mt_addr,
  input  logic [31:0] mt_wtag,
  output logic [31:0] mt_rtag
);

  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int EXT_W   = 12 - IDX_W;
  localparam bit USE_EXT = (EXT_W > 0);
  localparam int EXT_WP  = USE_EXT ? EXT_W : 1;

  ctc_state_t state, state_n;
  logic [1:0] beat, beat_n;
  logic       rspv_n, rspf_n;
  logic [31:0] rspd_n;
  logic [31:0] cap_q, cap_n;
  logic        hit_q, hit_n;
  logic        ld_req;

  logic [31:0] rq_addr, rq_wdata;
  logic [2:0]  rq_ctx;
  logic [3:0]  rq_be;
  logic        rq_write, rq_super, rq_pw, rq_pp, rq_en;

  logic              busy;
  ctc_tag_t          rd_tag, mrd_tag, tag_wdat;
  logic [EXT_WP-1:0] rd_ext, rq_ext, mt_ext, tag_wext;
  logic              tag_we;
  logic [IDX_W-1:0]  rq_idx, mt_idx, tag_widx;
  logic              dat_we;
  logic [1:0]        dat_word;
  logic [3:0]        dat_be;
  logic [31:0]       dat_wd, dat_rd;
  logic              hit, prot, mt_fire, req_fire;

  assign rq_idx = rq_addr[4 +: IDX_W];
  assign mt_idx = mt_addr[4 +: IDX_W];

  generate
    if (USE_EXT) begin : g_ext
      assign rq_ext = rq_addr[4 + IDX_W +: EXT_WP];
      assign mt_ext = mt_addr[4 + IDX_W +: EXT_WP];
    end else begin : g_noext
      assign rq_ext = '0;
      assign mt_ext = '0;
    end
  endgenerate

  logic unused_bits;
  assign unused_bits = ^{mt_addr[31:16], mt_addr[3:0], mt_wtag[31:25], mt_wtag[18:16], mt_wtag[1:0]};

  ctc_tag_store #(
    .LINES(NUM_LINES), .IDX_W(IDX_W), .USE_EXT(USE_EXT), .EXT_WP(EXT_WP)
  ) i_tags (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .rd_idx(rq_idx), .rd_tag(rd_tag), .rd_ext(rd_ext),
    .mrd_idx(mt_idx), .mrd_tag(mrd_tag),
    .wr_en(tag_we), .wr_idx(tag_widx), .wr_tag(tag_wdat), .wr_ext(tag_wext)
  );

  ctc_data_store #(.LINES(NUM_LINES), .IDX_W(IDX_W)) i_data (
    .clk(clk), .rd_idx(rq_idx), .rd_word(rq_addr[3:2]), .rd_data(dat_rd),
    .wr_en(dat_we), .wr_idx(rq_idx), .wr_word(dat_word), .wr_be(dat_be), .wr_data(dat_wd)
  );

  assign mt_ready  = (state == ST_IDLE) && !busy;
  assign req_ready = mt_ready && !mt_valid;
  assign mt_fire   = mt_valid && mt_ready;
  assign req_fire  = req_valid && req_ready;

  assign hit  = rd_tag.vld && (rd_tag.tid == rq_addr[29:16]) &&
                (rd_tag.ctx == rq_ctx) && (rd_ext == rq_ext);
  assign prot = (rq_write && !rd_tag.wr_ok) || (!rq_super && rd_tag.priv);

  assign mem_req   = (state == ST_WRITE) || (state == ST_FILL) || (state == ST_BYP);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = (state == ST_FILL) ? {rq_addr[31:4], beat, 2'b00} : {rq_addr[31:2], 2'b00};
  assign mem_wdata = rq_wdata;
  assign mem_be    = (state == ST_WRITE) ? rq_be : 4'hF;

  always_comb begin
    state_n  = state;
    beat_n   = beat;
    cap_n    = cap_q;
    hit_n    = hit_q;
    rspv_n   = 1'b0;
    rspf_n   = 1'b0;
    rspd_n   = 32'd0;
    ld_req   = 1'b0;
    tag_we   = 1'b0;
    tag_widx = rq_idx;
    tag_wext = rq_ext;
    tag_wdat = '{ctx: rq_ctx, wr_ok: rq_pw, priv: rq_pp, vld: 1'b1, tid: rq_addr[29:16]};
    dat_we   = 1'b0;
    dat_word = rq_addr[3:2];
    dat_be   = rq_be;
    dat_wd   = rq_wdata;
    case (state)
      ST_IDLE: begin
        if (mt_fire && mt_write) begin
          tag_we   = 1'b1;
          tag_widx = mt_idx;
          tag_wext = mt_ext;
          tag_wdat = ctc_unpack(mt_wtag);
        end else if (req_fire) begin
          ld_req  = 1'b1;
          state_n = ST_LOOK;
        end
      end
      ST_LOOK: begin
        hit_n = hit && rq_en;
        if (!rq_en) begin
          state_n = rq_write ? ST_WRITE : ST_BYP;
        end else if (hit && prot) begin
          rspv_n  = 1'b1;
          rspf_n  = 1'b1;
          state_n = ST_IDLE;
        end else if (rq_write) begin
          state_n = ST_WRITE;
        end else if (hit) begin
          rspv_n  = 1'b1;
          rspd_n  = dat_rd;
          state_n = ST_IDLE;
        end else begin
          beat_n  = 2'd0;
          state_n = ST_FILL;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          dat_we  = hit_q;
          rspv_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          dat_we   = 1'b1;
          dat_word = beat;
          dat_be   = 4'hF;
          dat_wd   = mem_rdata;
          beat_n   = beat + 2'd1;
          if (beat == rq_addr[3:2]) cap_n = mem_rdata;
          if (beat == 2'd3) begin
            tag_we  = 1'b1;
            rspv_n  = 1'b1;
            rspd_n  = (beat == rq_addr[3:2]) ? mem_rdata : cap_q;
            state_n = ST_IDLE;
          end
        end
      end
      ST_BYP: begin
        if (mem_ack) begin
          rspv_n  = 1'b1;
          rspd_n  = mem_rdata;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat      <= 2'd0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      state     <= state_n;
      beat      <= beat_n;
      rsp_valid <= rspv_n;
      rsp_fault <= rspf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      rq_addr  <= req_vaddr;
      rq_write <= req_write;
      rq_ctx   <= req_ctx;
      rq_super <= req_super;
      rq_wdata <= req_wdata;
      rq_be    <= req_be;
      rq_pw    <= req_pte_w;
      rq_pp    <= req_pte_p;
      rq_en    <= cache_en;
    end
    if (rspv_n) rsp_rdata <= rspd_n;
    if (mt_fire && !mt_write) mt_rtag <= ctc_pack(mrd_tag);
    cap_q <= cap_n;
    hit_q <= hit_n;
  end

  // R3
  fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) && mem_ack |=> ((state == ST_FILL) && (beat == $past(beat) + 2'd1)) || (state == ST_IDLE));

  // R5
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOK) && rq_write && !(rq_en && hit && prot) |=> (state == ST_WRITE) && mem_req);

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOK) && rq_en && hit && prot |=> rsp_valid && rsp_fault && !mem_req && (rsp_rdata == 32'd0));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_ctag_cache.sv
module test_ctag_cache;
  localparam int LINES = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cache_en, req_valid, req_write, req_super, req_pte_w, req_pte_p;
  logic        req_ready, rsp_valid, rsp_fault, mem_req, mem_we, mt_valid, mt_ready, mt_write;
  logic [31:0] req_vaddr, req_wdata, rsp_rdata, mem_addr, mem_wdata, mt_addr, mt_wtag, mt_rtag;
  logic [2:0]  req_ctx;
  logic [3:0]  req_be, mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;

  ctag_cache #(.NUM_LINES(LINES)) i_ctag_cache (.*);

  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  logic [31:0] rd_log [8];
  logic [31:0] last_wa, last_wd;
  logic [3:0]  last_be;
  logic [31:0] mdl [bit [29:0]];

  function automatic logic [31:0] mrd(input logic [31:0] a);
    bit [29:0] k;
    k = {a[29:2], 2'b00};
    if (mdl.exists(k)) return mdl[k];
    return {2'b00, a[29:2]} ^ 32'h5A5A_3C3C;
  endfunction

  function automatic logic [31:0] mk(input int tid, input int ext, input int line, input int word);
    return {2'b00, 14'(tid), 8'(ext), 4'(line), 2'(word), 2'b00};
  endfunction

  function automatic logic [31:0] tword(input int cx, input int w, input int p, input int v, input int tid);
    return (32'(cx) << 22) | (32'(w) << 21) | (32'(p) << 20) | (32'(v) << 19) | (32'(tid & 16'h3FFF) << 2);
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        logic [31:0] o;
        o = mrd(mem_addr);
        for (int b = 0; b < 4; b++) if (mem_be[b]) o[b*8 +: 8] = mem_wdata[b*8 +: 8];
        mdl[{mem_addr[29:2], 2'b00}] = o;
        last_wa = mem_addr; last_wd = mem_wdata; last_be = mem_be;
        n_wr++;
      end else begin
        mem_rdata <= mrd(mem_addr);
        rd_log[n_rd % 8] = mem_addr;
        n_rd++;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [31:0] a, input int cx, input logic sup,
                     input logic [31:0] wd, input logic [3:0] be, input logic pw, input logic pp,
                     output logic [31:0] rd, output logic flt);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = a; req_ctx = 3'(cx); req_super = sup;
    req_wdata = wd; req_be = be; req_pte_w = pw; req_pte_p = pp;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; flt = rsp_fault;
  endtask

  task automatic mt(input logic wr, input logic [31:0] a, input logic [31:0] wt, output logic [31:0] rt);
    @(negedge clk);
    mt_valid = 1'b1; mt_write = wr; mt_addr = a; mt_wtag = wt;
    while (!mt_ready) @(negedge clk);
    @(negedge clk);
    mt_valid = 1'b0;
    rt = mt_rtag;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, a, b, t, old, ex;
    logic f;
    int r0, w0, cyc;
    rst_n = 1'b0; cache_en = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    req_ctx = '0; req_super = 1'b0; req_wdata = '0; req_be = '0; req_pte_w = 1'b0; req_pte_p = 1'b0;
    mt_valid = 1'b0; mt_write = 1'b0; mt_addr = '0; mt_wtag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready low in sweep", 32'(req_ready), 32'd0);
    cyc = 1;
    while (!req_ready) begin @(negedge clk); cyc++; end
    chk("R1 sweep length", 32'(cyc >= LINES), 32'd1);
    mt(1'b0, mk(0, 0, 5, 0), 32'd0, t);
    chk("R1 tag cleared", t, 32'd0);

    // R3 R4 R8: every line filled, hit, tag read back
    for (int l = 0; l < LINES; l++) begin
      a = mk(l + 3, 0, l, l % 4);
      r0 = n_rd;
      acc(1'b0, a, l % 8, 1'b1, 0, 0, 1'(l % 2), 1'b0, d, f);
      chk("R3 fill data", d, mrd(a));
      chk("R3 beat count", 32'(n_rd - r0), 32'd4);
      for (int k = 0; k < 4; k++) chk("R3 beat order", rd_log[(r0 + k) % 8], {a[31:4], 2'(k), 2'b00});
      b = a ^ 32'h4;
      r0 = n_rd;
      acc(1'b0, b, l % 8, 1'b0, 0, 0, 1'b0, 1'b0, d, f);
      chk("R4 hit data", d, mrd(b));
      chk("R4 hit no memory", 32'(n_rd - r0), 32'd0);
      mt(1'b0, a, 32'd0, t);
      chk("R8 tag word", t, tword(l % 8, l % 2, 0, 1, l + 3));
    end

    // R2 upper bits ignored
    a = mk(3, 0, 0, 0) | 32'hC000_0000;
    r0 = n_rd;
    acc(1'b0, a, 0, 1'b1, 0, 0, 1'b0, 1'b0, d, f);
    chk("R2 high bits hit", 32'(n_rd - r0), 32'd0);
    chk("R2 high bits data", d, mrd(a));

    // R4 context, tag and upper index mismatches
    r0 = n_rd;
    acc(1'b0, mk(4, 0, 1, 0), 2, 1'b1, 0, 0, 1'b1, 1'b0, d, f);
    chk("R4 ctx mismatch refill", 32'(n_rd - r0), 32'd4);
    r0 = n_rd;
    acc(1'b0, mk(99, 0, 2, 0), 2, 1'b1, 0, 0, 1'b1, 1'b0, d, f);
    chk("R4 tag mismatch refill", 32'(n_rd - r0), 32'd4);
    r0 = n_rd;
    acc(1'b0, mk(11, 1, 8, 0), 0, 1'b1, 0, 0, 1'b1, 1'b0, d, f);
    chk("R2 upper index mismatch refill", 32'(n_rd - r0), 32'd4);

    // R5 R6 all byte-enable patterns on a writable hit line (line 3)
    a = mk(6, 0, 3, 1);
    for (int be = 0; be < 16; be++) begin
      old = mrd(a);
      b = 32'h1122_3344 * 32'(be + 1);
      ex = old;
      for (int k = 0; k < 4; k++) if (be[k]) ex[k*8 +: 8] = b[k*8 +: 8];
      w0 = n_wr;
      acc(1'b1, a, 3, 1'b1, b, 4'(be), 1'b1, 1'b0, d, f);
      chk("R5 store forwarded", 32'(n_wr - w0), 32'd1);
      chk("R5 store address", last_wa, {a[31:2], 2'b00});
      chk("R5 store enables", 32'(last_be), 32'(be));
      r0 = n_rd;
      acc(1'b0, a, 3, 1'b1, 0, 0, 1'b0, 1'b0, d, f);
      chk("R6 merged data", d, ex);
      chk("R6 still a hit", 32'(n_rd - r0), 32'd0);
    end

    // R5 store miss does not allocate
    a = mk(500, 0, 9, 0);
    w0 = n_wr;
    acc(1'b1, a, 1, 1'b1, 32'hCAFE_F00D, 4'hF, 1'b1, 1'b0, d, f);
    chk("R5 miss store forwarded", 32'(n_wr - w0), 32'd1);
    chk("R5 miss store data", last_wd, 32'hCAFE_F00D);
    r0 = n_rd;
    acc(1'b0, a, 1, 1'b1, 0, 0, 1'b1, 1'b0, d, f);
    chk("R5 no allocate", 32'(n_rd - r0), 32'd4);
    chk("R5 data from memory", d, 32'hCAFE_F00D);

    // R7 store to read-only line 0
    a = mk(3, 0, 0, 2);
    old = mrd(a);
    w0 = n_wr;
    acc(1'b1, a, 0, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b0, d, f);
    chk("R7 write fault", 32'(f), 32'd1);
    chk("R7 fault data", d, 32'd0);
    chk("R7 no memory write", 32'(n_wr - w0), 32'd0);
    r0 = n_rd;
    acc(1'b0, a, 0, 1'b1, 0, 0, 1'b0, 1'b0, d, f);
    chk("R7 cache unchanged", d, old);
    chk("R7 line still valid", 32'(n_rd - r0), 32'd0);

    // R7 R9 privileged line via maintenance write
    a = mk(7, 0, 4, 0);
    mt(1'b1, a, tword(4, 1, 1, 1, 7), t);
    r0 = n_rd;
    acc(1'b0, a, 4, 1'b0, 0, 0, 1'b0, 1'b0, d, f);
    chk("R7 user fault", 32'(f), 32'd1);
    chk("R7 user no memory", 32'(n_rd - r0), 32'd0);
    acc(1'b0, a, 4, 1'b1, 0, 0, 1'b0, 1'b0, d, f);
    chk("R7 supervisor ok", 32'(f), 32'd0);
    chk("R7 supervisor data", d, mrd(a));

    // R9 replace with junk in zero fields, then flush
    a = mk(13, 0, 10, 0);
    mt(1'b1, a, tword(5, 1, 0, 1, 13) | 32'hFE07_0003, t);
    mt(1'b0, a, 32'd0, t);
    chk("R9 zero fields forced", t, tword(5, 1, 0, 1, 13));
    r0 = n_rd;
    acc(1'b0, a, 5, 1'b1, 0, 0, 1'b0, 1'b0, d, f);
    chk("R9 replaced ctx hits", 32'(n_rd - r0), 32'd0);
    a = mk(14, 0, 11, 0);
    mt(1'b1, a, 32'd0, t);
    r0 = n_rd;
    acc(1'b0, a, 3, 1'b1, 0, 0, 1'b0, 1'b0, d, f);
    chk("R9 flush misses", 32'(n_rd - r0), 32'd4);

    // R10 bypass
    a = mk(15, 0, 12, 0);
    old = mrd(a);
    cache_en = 1'b0;
    r0 = n_rd;
    acc(1'b0, a, 4, 1'b1, 0, 0, 1'b0, 1'b0, d, f);
    chk("R10 single read", 32'(n_rd - r0), 32'd1);
    chk("R10 read data", d, old);
    w0 = n_wr;
    acc(1'b1, a, 4, 1'b1, 32'h0BAD_CAFE, 4'hF, 1'b0, 1'b0, d, f);
    chk("R10 no fault", 32'(f), 32'd0);
    chk("R10 write forwarded", 32'(n_wr - w0), 32'd1);
    b = mk(777, 0, 13, 0);
    r0 = n_rd;
    acc(1'b0, b, 0, 1'b1, 0, 0, 1'b1, 1'b0, d, f);
    chk("R10 uncached single read", 32'(n_rd - r0), 32'd1);
    cache_en = 1'b1;
    r0 = n_rd;
    acc(1'b0, a, 4, 1'b1, 0, 0, 1'b0, 1'b0, d, f);
    chk("R10 cache not updated", d, old);
    chk("R10 still a hit", 32'(n_rd - r0), 32'd0);
    r0 = n_rd;
    acc(1'b0, b, 0, 1'b1, 0, 0, 1'b1, 1'b0, d, f);
    chk("R10 no fill in bypass", 32'(n_rd - r0), 32'd4);

    summary();
    $finish;
  end
endmodule